// File: doc/BRIEF.md
# Branch History Table Predictor

This block predicts the direction of conditional branches at instruction fetch. It keeps a direct-mapped table of small saturating counters. The table is indexed by the word-address bits of the program counter just above the two byte-offset bits. A fetch-side lookup reads the counter selected by the fetch PC, and the counter's most significant bit gives the prediction in the same cycle.

When a branch resolves later in the pipeline, the execute side presents an update. The update carries the branch PC and the actual outcome. The selected counter steps toward taken or not taken and saturates at either end.

No address tag is kept, so branches whose index bits match share one counter. The counter width is a parameter. A width of 2 gives the classic hysteresis scheme, and a width of 1 gives a last-outcome table, so the two can be compared directly.

Top module: `bht_predictor`

## Requirements
- R1: Both the lookup and the update select entry PC[IDX_BITS+1:2] (bits 11:2 by default, 1024 entries). PC bits 1:0 and all bits above the index have no effect, so two PCs with equal index bits share one entry.
- R2: After reset every counter holds 2^(CTR_BITS-1)-1, the weakly not-taken value (01 with 2 bits, 0 with 1 bit). Every lookup then predicts not taken, and a single taken update to an entry makes it predict taken.
- R3: The prediction output is 1 (taken) exactly when the selected counter is at least 2^(CTR_BITS-1), i.e. the counter's top bit.
- R4: An update with outcome 1 (taken) increments the counter. It stays at 2^CTR_BITS-1 once there and never wraps to 0.
- R5: An update with outcome 0 (not taken) decrements the counter. It stays at 0 once there and never wraps to the maximum.
- R6: With 2-bit counters, an entry that has saturated in one direction changes its prediction only after two consecutive opposite outcomes.
- R7: With 1-bit counters, the prediction for an entry equals the outcome of the last update to it.
- R8: A lookup in the same cycle as an update to the same index returns the value held before that update. The update is visible to lookups from the next cycle on.
- R9: When the update strobe is low, no entry changes, whatever the update PC and outcome inputs hold.
- R10: For a loop branch that is taken nine times and then not taken once, repeated, the 1-bit table mispredicts twice per pass in steady state (80% accuracy), and the 2-bit table mispredicts once per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC for the lookup |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The lookup is combinational, so a prediction is due in the same cycle that lk_pc is applied. The bench drives every input just after a falling edge and reads lk_taken one nanosecond later, before the next rising edge. An update takes effect on the rising edge that samples up_valid, so its effect is read in the half cycle that follows. The same-cycle case reads the old value before that edge and the new value after it.

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int PC_W     = 32,
  parameter int IDX_BITS = 10,
  parameter int CTR_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int                  ENTRIES  = 1 << IDX_BITS;
  localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

  logic [CTR_BITS-1:0] tbl [ENTRIES];

  wire [IDX_BITS-1:0] lk_idx = lk_pc[IDX_BITS+1:2];
  wire [IDX_BITS-1:0] up_idx = up_pc[IDX_BITS+1:2];
  wire [CTR_BITS-1:0] up_old = tbl[up_idx];
  wire [CTR_BITS-1:0] lk_ctr = tbl[lk_idx];

  logic [CTR_BITS-1:0] up_new;
  always_comb begin
    up_new = up_old;
    if (up_taken && up_old != CTR_MAX) up_new = up_old + 1'b1;
    else if (!up_taken && up_old != '0) up_new = up_old - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
    end else if (up_valid) begin
      tbl[up_idx] <= up_new;
    end
  end

  assign lk_taken = lk_ctr[CTR_BITS-1];

  AST_TAKEN_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_taken |=> tbl[$past(up_idx)] >= $past(up_old)); // R4
  AST_TAKEN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_taken && up_old == CTR_MAX |=> tbl[$past(up_idx)] == CTR_MAX); // R4
  AST_NT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_taken |=> tbl[$past(up_idx)] <= $past(up_old)); // R5
  AST_NT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_taken && up_old == '0 |=> tbl[$past(up_idx)] == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> tbl[$past(lk_idx)] == $past(lk_ctr)); // R9
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && lk_idx != up_idx |=> tbl[$past(lk_idx)] == $past(lk_ctr)); // R1
endmodule

// File: tb/sim_bht_predictor.sv
`timescale 1ns/1ps
module sim_bht_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        p2, p1;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  bht_predictor #(.PC_W(32), .IDX_BITS(10), .CTR_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p2),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));
  bht_predictor #(.PC_W(32), .IDX_BITS(10), .CTR_BITS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc);
    @(negedge clk);
    lk_pc = pc;
    #1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      look(32'h40 * i + 32'h1000);
      chk("R2 reset 2b", p2, 0);
      chk("R2 reset 1b", p1, 0);
    end
  endtask

  task automatic t_first_taken;
    upd(32'h200, 1'b1);
    look(32'h200);
    chk("R2 one taken 2b", p2, 1);
    chk("R7 one taken 1b", p1, 1);
  endtask

  task automatic t_sat_high;
    for (int i = 0; i < 5; i++) upd(32'h300, 1'b1);
    upd(32'h300, 1'b0);
    look(32'h300);
    chk("R4/R6 one NT after sat 2b", p2, 1);
    chk("R7 one NT 1b", p1, 0);
    upd(32'h300, 1'b0);
    look(32'h300);
    chk("R6 two NT after sat 2b", p2, 0);
  endtask

  task automatic t_sat_low;
    for (int i = 0; i < 4; i++) upd(32'h400, 1'b0);
    upd(32'h400, 1'b1);
    look(32'h400);
    chk("R5/R6 one T after floor 2b", p2, 0);
    chk("R7 one T 1b", p1, 1);
    upd(32'h400, 1'b1);
    look(32'h400);
    chk("R3 two T after floor 2b", p2, 1);
  endtask

  task automatic t_index;
    upd(32'h100, 1'b1);
    upd(32'h100, 1'b1);
    look(32'h103);
    chk("R1 byte offset ignored", p2, 1);
    look(32'h0000_1100);
    chk("R1 alias above index", p2, 1);
    look(32'hFFFF_F100);
    chk("R1 alias high bits", p1, 1);
    look(32'h104);
    chk("R1 neighbour untouched", p2, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lk_pc = 32'h500; up_pc = 32'h500; up_taken = 1'b1; up_valid = 1'b1;
    #1;
    chk("R8 old value 2b", p2, 0);
    chk("R8 old value 1b", p1, 0);
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    chk("R8 new value 2b", p2, 1);
    chk("R8 new value 1b", p1, 1);
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    lk_pc = 32'h600; up_pc = 32'h600; up_taken = 1'b1; up_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R9 idle 2b", p2, 0);
    chk("R9 idle 1b", p1, 0);
  endtask

  task automatic t_loop;
    int m2, m1;
    m2 = 0; m1 = 0;
    for (int pass = 0; pass < 10; pass++) begin
      for (int it = 0; it < 10; it++) begin
        logic t;
        t = (it != 9);
        look(32'h700);
        if (pass > 0) begin
          if (p2 != t) m2++;
          if (p1 != t) m1++;
        end
        upd(32'h700, t);
      end
    end
    chk("R10 1b mispredicts over 9 passes", m1, 18);
    chk("R10 2b mispredicts over 9 passes", m2, 9);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_taken();
    t_sat_high();
    t_sat_low();
    t_index();
    t_same_cycle();
    t_no_strobe();
    t_loop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule